// File: doc/BRIEF.md
# Lane Ring Exchange and Global OR Network

This block lets a ring of 16-bit SIMD lanes exchange data in a single step. Each lane places the word it has read from its chosen source register on its own slice of the input bus. The block then gives back one result word per lane. A two-bit operation code selects how those results are formed. A lane can receive the word held by its higher-numbered neighbour or by its lower-numbered neighbour. As a third choice, every lane receives the bitwise OR of the words from all lanes.

The ring wraps around at the ends, with indices taken modulo the lane count. The network itself holds no state. Results change in the same cycle as the operands, so a lane can write the result into its register file during that same step. The global OR gathers the input word of every lane, whether that lane is enabled or not. Masking by the enable bit happens later, at the destination register, which lies outside this block. The lane count is a parameter from 1 to 16.

Top module: `lane_net`

## Requirements
- R1: With operation code 2'b00 (take from the upper neighbour), result lane i equals source lane (i+1) mod NPROC.
- R2: With operation code 2'b01 (take from the lower neighbour), result lane i equals source lane (i+NPROC-1) mod NPROC.
- R3: With operation code 2'b10 (global OR), every result lane equals the bitwise OR of all NPROC source words. Every lane's word contributes to this OR.
- R4: When NPROC is 1, codes 2'b00, 2'b01 and 2'b10 all return that lane's own source word.
- R5: Operation code 2'b11 is unused, and with it every result lane is 16'h0000.
- R6: Results are combinational. A change on the operation code or on the sources appears at the outputs without any clock edge.
- R7: Lane i occupies bits [16*i+15 : 16*i] of both the source bus and the result bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 2 | Operation code: 00 upper neighbour, 01 lower neighbour, 10 global OR, 11 unused |
| srcBus | input | 16*NPROC | Source word of each lane, lane 0 in the low bits |
| resBus | output | 16*NPROC | Result word for each lane, lane 0 in the low bits |

## Verification
The assertions assume that the operation code and the source bus carry known 0/1 values whenever they are evaluated. The bench keeps to this by driving every input explicitly before it samples anything. The permutation check assumes that a rotation only reorders the lanes, so the OR across all results equals the OR across all sources. The stimulus uses distinct words per lane, so a wrong rotation or a missing lane cannot hide behind repeated values.

// File: rtl/lane_net_pkg.sv
package lane_net_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_UPPER = 2'b00,
    OP_LOWER = 2'b01,
    OP_GOR   = 2'b10,
    OP_NONE  = 2'b11
  } netOp_e;

  typedef struct packed {
    logic takeUpper;
    logic takeLower;
    logic takeGor;
  } netStrobe_t;

endpackage

// File: rtl/lane_net_ctrl.sv
module lane_net_ctrl
  import lane_net_pkg::*;
(
  input  logic [1:0]  opSel,
  output netStrobe_t  strobe
);

  netOp_e opCode;

  always_comb begin
    opCode = netOp_e'(opSel);
    strobe = '0;
    unique case (opCode)
      OP_UPPER: strobe.takeUpper = 1'b1;
      OP_LOWER: strobe.takeLower = 1'b1;
      OP_GOR:   strobe.takeGor   = 1'b1;
      default:  strobe = '0;
    endcase
  end

  always_comb begin
    AST_STROBE_ONEHOT: assert ($onehot0({strobe.takeUpper, strobe.takeLower, strobe.takeGor})); // R5
    if (opSel == 2'b11) begin
      AST_UNUSED_IDLE: assert (strobe == '0); // R5
    end
  end

endmodule

// File: rtl/lane_net_dp.sv
module lane_net_dp
  import lane_net_pkg::*;
#(
  parameter int NPROC = 8
) (
  input  netStrobe_t                 strobe,
  input  logic [NPROC*WORD_W-1:0]    srcBus,
  output logic [NPROC*WORD_W-1:0]    resBus
);

  localparam int BUS_W = NPROC * WORD_W;

  logic [WORD_W-1:0] srcWord [NPROC];
  logic [WORD_W-1:0] resWord [NPROC];
  logic [WORD_W-1:0] gorWord;

  always_comb begin
    gorWord = '0;
    for (int k = 0; k < NPROC; k++) begin
      gorWord = gorWord | srcWord[k];
    end
  end

  for (genvar i = 0; i < NPROC; i++) begin : g_lane
    localparam int UP_IDX = (i + 1) % NPROC;
    localparam int LO_IDX = (i + NPROC - 1) % NPROC;

    assign srcWord[i] = srcBus[i*WORD_W +: WORD_W];

    always_comb begin
      if (strobe.takeUpper)      resWord[i] = srcWord[UP_IDX];
      else if (strobe.takeLower) resWord[i] = srcWord[LO_IDX];
      else if (strobe.takeGor)   resWord[i] = gorWord;
      else                       resWord[i] = '0;
    end

    assign resBus[i*WORD_W +: WORD_W] = resWord[i];
  end

  logic [WORD_W-1:0] chkSrcOr;
  logic [WORD_W-1:0] chkResOr;
  logic              chkAllSame;
  logic              chkCovered;
  logic              chkAllZero;

  always_comb begin
    chkSrcOr   = '0;
    chkResOr   = '0;
    chkAllSame = 1'b1;
    chkCovered = 1'b1;
    chkAllZero = 1'b1;
    for (int k = 0; k < NPROC; k++) begin
      chkSrcOr = chkSrcOr | srcBus[k*WORD_W +: WORD_W];
      chkResOr = chkResOr | resBus[k*WORD_W +: WORD_W];
      if (resBus[k*WORD_W +: WORD_W] != resBus[WORD_W-1:0]) chkAllSame = 1'b0;
      if (resBus[k*WORD_W +: WORD_W] != '0) chkAllZero = 1'b0;
    end
    for (int k = 0; k < NPROC; k++) begin
      if ((srcBus[k*WORD_W +: WORD_W] & ~resBus[WORD_W-1:0]) != '0) chkCovered = 1'b0;
    end
    if (strobe.takeUpper) begin
      AST_UPPER_PERMUTES: assert (chkResOr == chkSrcOr); // R1
    end
    if (strobe.takeLower) begin
      AST_LOWER_PERMUTES: assert (chkResOr == chkSrcOr); // R2
    end
    if (strobe.takeGor) begin
      AST_GOR_UNIFORM: assert (chkAllSame); // R3
      AST_GOR_COVERS: assert (chkCovered); // R3
    end
    if (strobe == '0) begin
      AST_IDLE_ZERO: assert (chkAllZero); // R5
    end
    if (NPROC == 1 && strobe != '0) begin
      AST_SOLO_SELF: assert (resBus[WORD_W-1:0] == srcBus[WORD_W-1:0]); // R4
    end
  end

  logic unusedBusW;
  assign unusedBusW = (BUS_W == 0);

endmodule

// File: rtl/lane_net.sv
module lane_net
  import lane_net_pkg::*;
#(
  parameter int NPROC = 8
) (
  input  logic [1:0]                 opSel,
  input  logic [NPROC*WORD_W-1:0]    srcBus,
  output logic [NPROC*WORD_W-1:0]    resBus
);

  netStrobe_t strobe;

  lane_net_ctrl ctrl_i (
    .opSel  (opSel),
    .strobe (strobe)
  );

  lane_net_dp #(.NPROC(NPROC)) dp_i (
    .strobe (strobe),
    .srcBus (srcBus),
    .resBus (resBus)
  );

endmodule

// File: tb/lane_net_tb_top.sv
module lane_net_tb_top;

  localparam int NP = 8;
  localparam int W  = 16;
  localparam int NVEC = 8;

  localparam logic [17:0] VEC_TAB [NVEC] = '{
    {2'b00, 16'h1234},
    {2'b01, 16'h1234},
    {2'b10, 16'h0001},
    {2'b11, 16'hFFFF},
    {2'b00, 16'hA5C3},
    {2'b01, 16'h0F0F},
    {2'b10, 16'h8000},
    {2'b10, 16'h3C5A}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [1:0]        opSel;
  logic [NP*W-1:0]   srcBus;
  logic [NP*W-1:0]   resBus;
  logic [1:0]        opSolo;
  logic [W-1:0]      srcSolo;
  logic [W-1:0]      resSolo;

  lane_net #(.NPROC(NP)) dut_i (
    .opSel  (opSel),
    .srcBus (srcBus),
    .resBus (resBus)
  );

  lane_net #(.NPROC(1)) solo_i (
    .opSel  (opSolo),
    .srcBus (srcSolo),
    .resBus (resSolo)
  );

  function automatic logic [W-1:0] laneWord(input logic [W-1:0] seed, input int lane);
    logic [W-1:0] w;
    w = seed ^ W'(lane * 16'h1111);
    w = w | (16'h0001 << lane);
    return w;
  endfunction

  function automatic logic [W-1:0] expectLane(input logic [1:0] op,
                                              input logic [NP*W-1:0] src,
                                              input int lane);
    logic [W-1:0] acc;
    case (op)
      2'b00: return src[((lane + 1) % NP)*W +: W];
      2'b01: return src[((lane + NP - 1) % NP)*W +: W];
      2'b10: begin
        acc = '0;
        for (int k = 0; k < NP; k++) acc = acc | src[k*W +: W];
        return acc;
      end
      default: return '0;
    endcase
  endfunction

  function automatic string reqOf(input logic [1:0] op);
    case (op)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic checkBus(input string req);
    for (int l = 0; l < NP; l++) begin
      check(req, resBus[l*W +: W], expectLane(opSel, srcBus, l));
    end
  endtask

  initial begin
    opSel = 2'b11;
    srcBus = '0;
    opSolo = 2'b11;
    srcSolo = '0;
    @(negedge clk);
    for (int l = 0; l < NP; l++) check("R5", resBus[l*W +: W], 16'h0000);

    for (int v = 0; v < NVEC; v++) begin
      @(posedge clk);
      opSel = VEC_TAB[v][17:16];
      for (int l = 0; l < NP; l++) srcBus[l*W +: W] = laneWord(VEC_TAB[v][15:0], l);
      @(negedge clk);
      checkBus(reqOf(opSel));
    end

    // R7: one-hot lane placement, lane 0 in the low bits
    @(posedge clk);
    opSel = 2'b00;
    srcBus = '0;
    srcBus[3*W +: W] = 16'hBEEF;
    @(negedge clk);
    check("R7", resBus[2*W +: W], 16'hBEEF);
    check("R7", resBus[3*W +: W], 16'h0000);
    opSel = 2'b01;
    #1;
    check("R7", resBus[4*W +: W], 16'hBEEF);

    // R3: a single set bit in the last lane reaches every lane
    @(posedge clk);
    opSel = 2'b10;
    srcBus = '0;
    srcBus[(NP-1)*W +: W] = 16'h4000;
    @(negedge clk);
    for (int l = 0; l < NP; l++) check("R3", resBus[l*W +: W], 16'h4000);

    // R1/R2 wraparound at both ends
    @(posedge clk);
    for (int l = 0; l < NP; l++) srcBus[l*W +: W] = W'(16'h0100 + l);
    opSel = 2'b00;
    @(negedge clk);
    check("R1", resBus[(NP-1)*W +: W], 16'h0100);
    opSel = 2'b01;
    #1;
    check("R2", resBus[0 +: W], W'(16'h0100 + NP - 1));

    // R6: change between edges, observe without any clock edge
    opSel = 2'b10;
    srcBus[0 +: W] = 16'h8000;
    #0.5;
    check("R6", resBus[5*W +: W], 16'h8107);
    opSel = 2'b11;
    #0.5;
    check("R6", resBus[5*W +: W], 16'h0000);

    // R4: single lane
    for (int op = 0; op < 3; op++) begin
      @(posedge clk);
      opSolo = 2'(op);
      srcSolo = W'(16'hC001 + op);
      @(negedge clk);
      check("R4", resSolo, W'(16'hC001 + op));
    end
    @(posedge clk);
    opSolo = 2'b11;
    @(negedge clk);
    check("R5", resSolo, 16'h0000);

    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule